// File: doc/BRIEF.md
# Gate Schedule Command Encoder

This block turns a list of timed gate entries into the command words that a scheduled-traffic engine reads from a 64-slot command bank. Each entry holds an interval in nanoseconds and a gate mask. The encoder converts the interval into a transfer count that matches the link speed: a byte count at 1000 Mb/s and above, and a nibble count below that. A count too large for one 14-bit command field is spread over several commands that carry the same mask. The encoder then writes the commands one per cycle, from address 0 upward, through a simple RAM write port.

The work runs in two passes. In the collection pass, `start` opens the run and the entries arrive over a valid/ready handshake, with `ent_last` marking the final one. Each entry's count and mask are held internally and the number of commands the list needs is added up. If that number fits in the bank, the write pass emits the commands. If one slot is still free after them, it appends a closing command that releases every gate no entry used. If the list does not fit, nothing is written and the run ends with an error flag.

Top module: `gate_cmd_encoder`

## Requirements
- R1: At `link_mbps` >= 1000 the count of an entry is ceil(interval_ns * link_mbps / 8000).
- R2: At `link_mbps` < 1000 the count is ceil(2 * interval_ns * link_mbps / 8000).
- R3: Each command is `wr_data` = {count[13:0] in bits 21:8, mask in bits 7:0}. Commands go to consecutive addresses starting at 0. A count above 16383 produces commands of 16383 first, then one command with the remainder, and all of them carry the entry's mask.
- R4: A final (or only) command of an entry whose count is between 1 and 15 is written with count 16.
- R5: An entry whose count is 0 produces one command with count 0. Every entry after it in the same run is accepted but produces no command and does not contribute to the closing mask.
- R6: When the entry commands number fewer than 64, one more command follows at the next address, with count 0 and mask equal to the bitwise inverse of the OR of the masks of all encoded entries. With exactly 64 entry commands there is no closing command.
- R7: When the entry commands would number more than 64, no write occurs and the run ends with `err` high together with `done`.
- R8: Only bits 7:0 of `ent_mask` are used. Higher bits affect neither the commands nor the closing mask.
- R9: `done` is a single-cycle pulse. It comes in the cycle after the last write, or, on an error, in the cycle after the last entry is accepted. `ent_ready` is high only during collection and never during a write.
- R10: After reset, `ent_ready`, `wr_en`, `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a run when the block is idle |
| link_mbps | input | SPD_W | Link speed in Mb/s, held stable during collection |
| ent_valid | input | 1 | Entry present |
| ent_ready | output | 1 | Entry accepted when high with `ent_valid` |
| ent_ns | input | NS_W | Entry interval in nanoseconds |
| ent_mask | input | MASK_IN_W | Entry gate mask, bits 7:0 used |
| ent_last | input | 1 | Marks the final entry of the list |
| wr_en | output | 1 | Command write strobe |
| wr_addr | output | 6 | Command bank address |
| wr_data | output | 22 | Command word {count, mask} |
| done | output | 1 | End-of-run pulse |
| err | output | 1 | Capacity exceeded, valid with `done` |

## Verification
The assertions assume that `start` is only raised while the block is idle and that `link_mbps` does not change while entries are being collected. They also assume that every list ends with an entry flagged by `ent_last`. The bench respects these conditions. It pulses `start` once per run and sets the speed before that pulse. It waits for `done` before the next run, and it always marks the final entry of each list it drives. Capacity limits are probed with lists that need exactly 63, 64 and 65 commands, and with single entries that split into more than 64 commands.

// File: rtl/gce_pkg.sv
package gce_pkg;
    localparam int unsigned CMD_CNT_W  = 14;
    localparam int unsigned MASK_W     = 8;
    localparam int unsigned CMD_W      = CMD_CNT_W + MASK_W;
    localparam int unsigned CNT_LIMIT  = (1 << CMD_CNT_W) - 1;
    localparam int unsigned CNT_FLOOR  = 16;
    localparam int unsigned GIGA_MBPS  = 1000;
    localparam int unsigned NS_PER_DIV = 8000;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_COLLECT = 3'd1,
        ST_WRITE   = 3'd2,
        ST_CLOSE   = 3'd3,
        ST_FIN     = 3'd4
    } gce_state_e;
endpackage

// File: rtl/gce_conv.sv
module gce_conv
    import gce_pkg::*;
#(
    parameter int unsigned NS_W   = 24,
    parameter int unsigned SPD_W  = 14,
    parameter int unsigned CNT_W  = 28,
    parameter int unsigned NCMD_W = 15
) (
    input  logic [NS_W-1:0]   interval_ns,
    input  logic [SPD_W-1:0]  speed_mbps,
    output logic [CNT_W-1:0]  count,
    output logic [NCMD_W-1:0] n_cmds
);
    localparam int unsigned PROD_W = NS_W + SPD_W + 2;

    logic [PROD_W-1:0] prod;
    logic [CNT_W:0]    cnt_ext;

    always_comb begin
        prod = PROD_W'(interval_ns) * PROD_W'(speed_mbps);
        if (speed_mbps < SPD_W'(GIGA_MBPS)) begin
            prod = prod << 1;
        end
        count   = CNT_W'((prod + PROD_W'(NS_PER_DIV - 1)) / PROD_W'(NS_PER_DIV));
        cnt_ext = {1'b0, count} + (CNT_W + 1)'(CNT_LIMIT - 1);
        if (count == '0) begin
            n_cmds = NCMD_W'(1);
        end else begin
            n_cmds = NCMD_W'(cnt_ext / (CNT_W + 1)'(CNT_LIMIT));
        end
    end
endmodule

// File: rtl/gce_store.sv
module gce_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 36,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            slots[waddr] <= wdata;
        end
    end

    assign rdata = slots[raddr];
endmodule

// File: rtl/gate_cmd_encoder.sv
module gate_cmd_encoder
    import gce_pkg::*;
#(
    parameter int unsigned NS_W       = 24,
    parameter int unsigned SPD_W      = 14,
    parameter int unsigned MASK_IN_W  = 10,
    parameter int unsigned BANK_DEPTH = 64,
    localparam int unsigned AW        = $clog2(BANK_DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [SPD_W-1:0]     link_mbps,
    input  logic                 ent_valid,
    output logic                 ent_ready,
    input  logic [NS_W-1:0]      ent_ns,
    input  logic [MASK_IN_W-1:0] ent_mask,
    input  logic                 ent_last,
    output logic                 wr_en,
    output logic [AW-1:0]        wr_addr,
    output logic [CMD_W-1:0]     wr_data,
    output logic                 done,
    output logic                 err
);
    localparam int unsigned IDX_W  = AW + 1;
    localparam int unsigned CNT_W  = NS_W + SPD_W + 2 - 12;
    localparam int unsigned NCMD_W = CNT_W - 13;
    localparam int unsigned ENT_W  = CNT_W + MASK_W;
    localparam logic [IDX_W-1:0] DEPTH_I = IDX_W'(BANK_DEPTH);

    typedef struct packed {
        gce_state_e        st;
        logic [IDX_W-1:0]  n_ent;
        logic [IDX_W-1:0]  total;
        logic              halted;
        logic [MASK_W-1:0] or_mask;
        logic [IDX_W-1:0]  idx;
        logic [CNT_W-1:0]  rem;
        logic              fresh;
        logic [AW-1:0]     addr;
        logic              err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [MASK_W-1:0] mask8;
    logic [CNT_W-1:0]  ent_cnt;
    logic [NCMD_W-1:0] ent_ncmd;
    logic              st_we;
    logic [ENT_W-1:0]  st_rdata;
    logic [CNT_W-1:0]  rd_cnt;
    logic [MASK_W-1:0] rd_mask;

    generate
        if (MASK_IN_W > MASK_W) begin : g_wide_mask
            logic hi_bits_unused;
            assign mask8          = ent_mask[MASK_W-1:0];
            assign hi_bits_unused = ^ent_mask[MASK_IN_W-1:MASK_W];
        end else begin : g_narrow_mask
            assign mask8 = MASK_W'(ent_mask);
        end
    endgenerate

    gce_conv #(
        .NS_W   (NS_W),
        .SPD_W  (SPD_W),
        .CNT_W  (CNT_W),
        .NCMD_W (NCMD_W)
    ) u_conv (
        .interval_ns (ent_ns),
        .speed_mbps  (link_mbps),
        .count       (ent_cnt),
        .n_cmds      (ent_ncmd)
    );

    gce_store #(
        .DEPTH (BANK_DEPTH),
        .DW    (ENT_W)
    ) u_store (
        .clk   (clk),
        .we    (st_we),
        .waddr (ctl_q.n_ent[AW-1:0]),
        .wdata ({ent_cnt, mask8}),
        .raddr (ctl_q.idx[AW-1:0]),
        .rdata (st_rdata)
    );

    assign rd_cnt  = st_rdata[ENT_W-1:MASK_W];
    assign rd_mask = st_rdata[MASK_W-1:0];

    logic [NCMD_W:0]      tot_sum;
    logic [IDX_W-1:0]     tot_new;
    logic [CNT_W-1:0]     cur;
    logic [CMD_CNT_W-1:0] chunk;

    always_comb begin
        ctl_d     = ctl_q;
        st_we     = 1'b0;
        wr_en     = 1'b0;
        wr_addr   = ctl_q.addr;
        wr_data   = '0;
        done      = 1'b0;
        err       = 1'b0;
        ent_ready = (ctl_q.st == ST_COLLECT);
        tot_sum   = (NCMD_W + 1)'(ctl_q.total) + (NCMD_W + 1)'(ent_ncmd);
        tot_new   = ctl_q.total;
        cur       = ctl_q.fresh ? rd_cnt : ctl_q.rem;
        chunk     = '0;

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d         = '0;
                    ctl_d.st      = ST_COLLECT;
                end
            end
            ST_COLLECT: begin
                if (ent_valid) begin
                    if (!ctl_q.halted) begin
                        tot_new = (tot_sum > (NCMD_W + 1)'(BANK_DEPTH)) ?
                                  DEPTH_I + 1'b1 : IDX_W'(tot_sum);
                        ctl_d.total   = tot_new;
                        ctl_d.or_mask = ctl_q.or_mask | mask8;
                        if (ctl_q.n_ent < DEPTH_I) begin
                            st_we       = 1'b1;
                            ctl_d.n_ent = ctl_q.n_ent + 1'b1;
                        end
                        if (ent_cnt == '0) begin
                            ctl_d.halted = 1'b1;
                        end
                    end
                    if (ent_last) begin
                        if (tot_new > DEPTH_I) begin
                            ctl_d.st  = ST_FIN;
                            ctl_d.err = 1'b1;
                        end else begin
                            ctl_d.st    = ST_WRITE;
                            ctl_d.idx   = '0;
                            ctl_d.fresh = 1'b1;
                            ctl_d.addr  = '0;
                        end
                    end
                end
            end
            ST_WRITE: begin
                wr_en      = 1'b1;
                ctl_d.addr = ctl_q.addr + 1'b1;
                if (cur > CNT_W'(CNT_LIMIT)) begin
                    chunk       = CMD_CNT_W'(CNT_LIMIT);
                    ctl_d.rem   = cur - CNT_W'(CNT_LIMIT);
                    ctl_d.fresh = 1'b0;
                end else begin
                    chunk = (cur != '0 && cur < CNT_W'(CNT_FLOOR)) ?
                            CMD_CNT_W'(CNT_FLOOR) : CMD_CNT_W'(cur);
                    ctl_d.fresh = 1'b1;
                    ctl_d.idx   = ctl_q.idx + 1'b1;
                    if (ctl_q.idx + 1'b1 == ctl_q.n_ent) begin
                        ctl_d.st = (ctl_q.total < DEPTH_I) ? ST_CLOSE : ST_FIN;
                    end
                end
                wr_data = {chunk, rd_mask};
            end
            ST_CLOSE: begin
                wr_en    = 1'b1;
                wr_data  = {CMD_CNT_W'(0), ~ctl_q.or_mask};
                ctl_d.st = ST_FIN;
            end
            ST_FIN: begin
                done     = 1'b1;
                err      = ctl_q.err;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/gate_cmd_encoder_chk.sv
module gate_cmd_encoder_chk #(
    parameter int unsigned AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ent_ready,
    input logic          wr_en,
    input logic [AW-1:0] wr_addr,
    input logic [21:0]   wr_data,
    input logic          done,
    input logic          err
);
    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);

    // R4
    min_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[21:8] == 14'd0 || wr_data[21:8] >= 14'd16));

    // R7
    err_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && err |-> !$past(wr_en));

    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_en) |-> done);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    ready_not_writing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !ent_ready);
endmodule

bind gate_cmd_encoder gate_cmd_encoder_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ent_ready (ent_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .done      (done),
    .err       (err)
);

// File: tb/gate_cmd_encoder_tb.sv
`timescale 1ns/1ps
module gate_cmd_encoder_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        start = 0;
    logic [13:0] link_mbps = 14'd1000;
    logic        ent_valid = 0;
    logic        ent_ready;
    logic [23:0] ent_ns = '0;
    logic [9:0]  ent_mask = '0;
    logic        ent_last = 0;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [21:0] wr_data;
    logic        done;
    logic        err;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;

    longint t_ns   [0:99];
    int     t_mask [0:99];
    logic [21:0] exp_data [0:127];
    int exp_n;
    bit exp_err;
    logic [5:0]  cap_addr [0:127];
    logic [21:0] cap_data [0:127];
    int cap_n, done_cnt;
    bit err_seen;
    longint last_wr_cyc, done_cyc;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    gate_cmd_encoder u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .link_mbps(link_mbps),
        .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_ns(ent_ns),
        .ent_mask(ent_mask), .ent_last(ent_last), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .err(err)
    );

    always @(negedge clk) begin
        if (wr_en) begin
            if (cap_n < 128) begin
                cap_addr[cap_n] = wr_addr;
                cap_data[cap_n] = wr_data;
            end
            cap_n++;
            last_wr_cyc = cyc;
        end
        if (done) begin
            done_cnt++;
            err_seen = err;
            done_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint count_of(input longint ns, input int spd);
        longint p = ns * spd;
        if (spd < 1000) p = p * 2;
        return (p + 7999) / 8000;
    endfunction

    task automatic build_expect(input int n, input int spd);
        int tot = 0;
        int orm = 0;
        exp_n = 0;
        for (int i = 0; i < n; i++) begin
            longint c = count_of(t_ns[i], spd);
            int m = t_mask[i] & 255;
            orm |= m;
            if (c == 0) begin
                if (exp_n < 128) exp_data[exp_n] = {14'd0, m[7:0]};
                exp_n++; tot++;
                break;
            end
            while (c > 16383) begin
                if (exp_n < 128) exp_data[exp_n] = {14'd16383, m[7:0]};
                exp_n++; tot++; c -= 16383;
            end
            if (c < 16) c = 16;
            if (exp_n < 128) exp_data[exp_n] = {c[13:0], m[7:0]};
            exp_n++; tot++;
        end
        exp_err = (tot > 64);
        if (exp_err) exp_n = 0;
        else if (tot < 64) begin
            exp_data[exp_n] = {14'd0, ~orm[7:0]};
            exp_n++;
        end
    endtask

    task automatic run_case(input int n, input int spd, input string tag);
        int k = 0;
        build_expect(n, spd);
        cap_n = 0; done_cnt = 0; err_seen = 0; last_wr_cyc = -1; done_cyc = -1;
        @(negedge clk);
        link_mbps = spd[13:0];
        start = 1;
        @(negedge clk);
        start = 0;
        check(ent_ready == 1'b1, {tag, " R9 ready in collect"}, ent_ready, 1);
        for (int i = 0; i < n; i++) begin
            ent_valid = 1;
            ent_ns    = t_ns[i][23:0];
            ent_mask  = t_mask[i][9:0];
            ent_last  = (i == n - 1);
            @(negedge clk);
        end
        ent_valid = 0; ent_last = 0;
        while (done_cnt == 0 && k < 400) begin
            @(negedge clk);
            k++;
        end
        @(negedge clk);
        @(negedge clk);
        check(done_cnt == 1, {tag, " R9 single done"}, done_cnt, 1);
        check(err_seen == exp_err, {tag, " R7 err flag"}, err_seen, exp_err);
        check(cap_n == exp_n, {tag, " write count"}, cap_n, exp_n);
        if (exp_n > 0)
            check(done_cyc == last_wr_cyc + 1, {tag, " R9 done timing"}, done_cyc, last_wr_cyc + 1);
        for (int i = 0; i < exp_n && i < cap_n && i < 128; i++) begin
            check(cap_addr[i] == i[5:0], {tag, " R3 address"}, cap_addr[i], i);
            check(cap_data[i] == exp_data[i], {tag, " data"}, cap_data[i], exp_data[i]);
        end
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int speeds [5] = '{10, 100, 1000, 2500, 10000};
        longint nss [8] = '{1, 40, 1000, 1001, 131064, 131104, 262128, 400000};
        repeat (3) @(negedge clk);
        // R10 reset state
        check(ent_ready == 0, "R10 ready", ent_ready, 0);
        check(wr_en == 0, "R10 wr_en", wr_en, 0);
        check(done == 0 && err == 0, "R10 done/err", done, 0);
        rst_n = 1;
        @(negedge clk);

        // R1 gigabit list
        t_ns[0] = 1000; t_mask[0] = 8'h81;
        t_ns[1] = 2000; t_mask[1] = 8'h02;
        t_ns[2] = 1001; t_mask[2] = 8'h10;
        run_case(3, 1000, "R1 gigabit");
        // R2 nibble mode
        run_case(3, 100, "R2 100M");
        run_case(3, 10, "R2 10M");
        // R3 split with remainder and exact multiple
        t_ns[0] = 200000; t_mask[0] = 8'h05;
        t_ns[1] = 262128; t_mask[1] = 8'h30;
        run_case(2, 1000, "R3 split");
        // R4 floor on short counts and tiny remainders
        t_ns[0] = 40;     t_mask[0] = 8'h01;
        t_ns[1] = 131104; t_mask[1] = 8'h02;
        run_case(2, 1000, "R4 floor");
        // R5 zero count halts the list
        t_ns[0] = 800; t_mask[0] = 8'h01;
        t_ns[1] = 0;   t_mask[1] = 8'h04;
        t_ns[2] = 800; t_mask[2] = 8'h40;
        t_ns[3] = 800; t_mask[3] = 8'h80;
        run_case(4, 1000, "R5 zero mid");
        t_ns[0] = 0; t_mask[0] = 8'h22;
        t_ns[1] = 500; t_mask[1] = 8'h11;
        run_case(2, 2500, "R5 zero first");
        // R8 upper mask bits dropped
        t_ns[0] = 1000; t_mask[0] = 10'h3F0;
        t_ns[1] = 1000; t_mask[1] = 10'h20F;
        run_case(2, 1000, "R8 wide mask");
        // R6 capacity edges
        for (int i = 0; i < 65; i++) begin
            t_ns[i] = 100 + i;
            t_mask[i] = i * 37;
        end
        run_case(63, 1000, "R6 63 cmds");
        run_case(64, 1000, "R6 64 cmds");
        // R7 overflow by entries and by one huge entry
        run_case(65, 1000, "R7 65 cmds");
        t_ns[0] = 9000000; t_mask[0] = 8'h0F;
        run_case(1, 1000, "R7 huge");
        t_ns[0] = 1000; t_mask[0] = 8'h0F;
        run_case(1, 1000, "R7 recovery");
        // R1 R2 R3 R4 sweep over speeds and intervals
        foreach (speeds[s]) begin
            foreach (nss[j]) begin
                t_ns[0] = nss[j];      t_mask[0] = 8'h01 << j;
                t_ns[1] = nss[7 - j];  t_mask[1] = 8'h03 << s;
                run_case(2, speeds[s], "R1 R2 R3 R4 sweep");
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule